// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects 32 peripheral interrupt lines, conditions each one (synchronisation, trigger mode, polarity), and steers every source to any set of four cores and any set of four parent interrupt lines per core. The result is sixteen outputs, one for each core and parent-line pair. Software sets the block up through a small register bus with a byte-address port, byte-lane enables and a combinational read path.

Each source has one route byte. The low nibble picks the cores and the high nibble picks the parent lines. Enables are changed only through a write-one-to-set register and a write-one-to-clear register, so a driver never needs a read-modify-write on a shared mask. A source in edge mode holds its pending flag until software writes a 1 to its bit in the status register. A source in level mode tracks its synchronised input.

Top module: `local_irq_router`

## Requirements
- R1: After reset every route byte reads 0x11, the enable mask (0x24), polarity (0x30) and mode (0x34) registers read 0, the status register (0x40) reads 0 and every bit of `irq_out` is low.
- R2: Source i owns the route byte at byte address i (0x00–0x1F), read as 32-bit words with source 4w+k in bits [8k+7:8k] of the word at 4w. A write updates only the bytes whose lane enable is set. Route bits [3:0] select cores 0–3 and bits [7:4] select parent lines 0–3.
- R3: Writing to 0x28 sets the enable of each source whose written bit is 1 and leaves every other enable unchanged. The mask reads back at 0x24.
- R4: Writing to 0x2C clears the enable of each source whose written bit is 1. Writing all ones disables every source, and the outputs of disabled sources fall.
- R5: A source with mode bit 0 is level triggered. It is pending while its synchronised input equals its polarity bit (1 = active high, 0 = active low), and it stops being pending when the input goes inactive.
- R6: A source with mode bit 1 latches a pending flag on a rising edge (polarity 1) or a falling edge (polarity 0) of its synchronised input. The flag stays set after the input returns, and the opposite edge does not set it.
- R7: The status register at 0x40 reads pending AND enabled. Writing 1 to a bit clears that source's edge latch, and bits written 0 have no effect. An edge detected in the same cycle as a clearing write leaves the latch set. Disabling a source hides its latch without losing it.
- R8: `irq_out[c*4+p]` is high when some status bit belongs to a source whose route byte has bit c and bit 4+p set. The output is registered, one clock after the status.
- R9: Each input passes through two flip-flops. A level-mode input change driven before clock edge 1 appears in the status after edge 2 and on `irq_out` after edge 3.
- R10: The polarity and mode registers are plain read/write at 0x30 and 0x34, honouring lane enables. All other word addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address, bits [1:0] ignored |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 32 | Raw peripheral interrupt lines |
| irq_out | output | 16 | Per-core parent lines, index core*4+line |

## Verification
Two functions can act on the same latch bit in the same cycle: a detected edge that sets it, and a status write that clears it. The bench drives a falling edge on an edge-mode source and times the clearing write so that it is sampled on the very clock at which the synchronised edge reaches the latch. It then reads the status back and expects the bit to be set. A later clearing write with no edge must then bring the bit to 0.

// File: rtl/local_irq_router.sv
module local_irq_router #(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int NPAR  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             bus_addr,
  input  logic                   bus_we,
  input  logic [3:0]             bus_be,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NSRC-1:0]        irq_in,
  output logic [NCORE*NPAR-1:0]  irq_out
);

  localparam int NOUT = NCORE * NPAR;
  localparam logic [7:0] ROUTE_RST = 8'h11;
  localparam logic [5:0] W_ENRD  = 6'h09;
  localparam logic [5:0] W_ENSET = 6'h0A;
  localparam logic [5:0] W_ENCLR = 6'h0B;
  localparam logic [5:0] W_POL   = 6'h0C;
  localparam logic [5:0] W_MODE  = 6'h0D;
  localparam logic [5:0] W_STS   = 6'h10;

  logic [7:0]      route_q [NSRC];
  logic [NSRC-1:0] en_q, pol_q, mode_q, lat_q;
  logic [NSRC-1:0] s1_q, s2_q, s3_q;
  logic [NOUT-1:0] out_q;

  logic [5:0]  widx;
  logic [31:0] bmask, wv;
  logic        rt_wr;

  assign widx  = bus_addr[7:2];
  assign bmask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  assign wv    = bus_wdata & bmask;
  assign rt_wr = bus_we && (bus_addr[7:5] == 3'b000);

  logic wr_set, wr_clr, wr_pol, wr_mode, wr_sts;
  assign wr_set  = bus_we && (widx == W_ENSET);
  assign wr_clr  = bus_we && (widx == W_ENCLR);
  assign wr_pol  = bus_we && (widx == W_POL);
  assign wr_mode = bus_we && (widx == W_MODE);
  assign wr_sts  = bus_we && (widx == W_STS);

  logic [NSRC-1:0] hit, lvl, pending, status, clr_v;
  assign hit     = mode_q & ((pol_q & s2_q & ~s3_q) | (~pol_q & ~s2_q & s3_q));
  assign lvl     = ~(s2_q ^ pol_q);
  assign clr_v   = wr_sts ? wv[NSRC-1:0] : '0;
  assign pending = (mode_q & lat_q) | (~mode_q & lvl);
  assign status  = pending & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= irq_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
      lat_q  <= '0;
    end else begin
      if (wr_set) en_q <= en_q | wv[NSRC-1:0];
      else if (wr_clr) en_q <= en_q & ~wv[NSRC-1:0];
      if (wr_pol)  pol_q  <= (pol_q & ~bmask[NSRC-1:0]) | wv[NSRC-1:0];
      if (wr_mode) mode_q <= (mode_q & ~bmask[NSRC-1:0]) | wv[NSRC-1:0];
      lat_q <= mode_q & (hit | (lat_q & ~clr_v));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) route_q[i] <= ROUTE_RST;
    end else if (rt_wr) begin
      for (int i = 0; i < NSRC; i++)
        if ((bus_addr[4:2] == 3'(i / 4)) && bus_be[i % 4])
          route_q[i] <= bus_wdata[8*(i%4) +: 8];
    end
  end

  logic [NSRC-1:0] core_sel [NCORE];
  logic [NSRC-1:0] par_sel  [NPAR];
  logic [NOUT-1:0] out_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    for (genvar c = 0; c < NCORE; c++) begin : g_c
      assign core_sel[c][i] = route_q[i][c];
    end
    for (genvar p = 0; p < NPAR; p++) begin : g_p
      assign par_sel[p][i] = route_q[i][NCORE+p];
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar p = 0; p < NPAR; p++) begin : g_par
      assign out_d[c*NPAR+p] = |(status & core_sel[c] & par_sel[p]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end
  assign irq_out = out_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[7:5] == 3'b000) begin
      for (int b = 0; b < 4; b++)
        bus_rdata[8*b +: 8] = route_q[{bus_addr[4:2], 2'(b)}];
    end else begin
      case (widx)
        W_ENRD:  bus_rdata[NSRC-1:0] = en_q;
        W_POL:   bus_rdata[NSRC-1:0] = pol_q;
        W_MODE:  bus_rdata[NSRC-1:0] = mode_q;
        W_STS:   bus_rdata[NSRC-1:0] = status;
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && widx == W_ENSET && bus_be == 4'hF)
      |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && widx == W_ENCLR && bus_be == 4'hF)
      |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

  a_r6_latch_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_q & ~$past(lat_q) & ~$past(hit)) == '0));

  a_r8_out_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_out) |-> $past(|status));

  a_r7_latch_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_q & ~$past(mode_q)) == '0));

endmodule

// File: tb/tb_local_irq_router.sv
module tb_local_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic [15:0] irq_out;

  int checks = 0;
  int errors = 0;

  local_irq_router dut (.*);

  always #4 clk = ~clk;

  localparam logic [7:0] A_ENRD = 8'h24, A_ENSET = 8'h28, A_ENCLR = 8'h2C;
  localparam logic [7:0] A_POL = 8'h30, A_MODE = 8'h34, A_STS = 8'h40;

  // [4:0] source, [6] polarity, [7] drive active, [15:8] route byte
  localparam logic [15:0] VEC [8] = '{
    16'h11C0, 16'h24C5, 16'hFFDF, 16'h114C,
    16'h8811, 16'h0FD4, 16'h8389, 16'h58DA
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_out(input logic act, input logic [7:0] r);
    logic [15:0] e = '0;
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 4; p++)
        e[c*4+p] = act & r[c] & r[4+p];
    return e;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    wait_n(3);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); chk("R1 route word0", d, 32'h11111111);
    rd(8'h1C, d); chk("R1 route word7", d, 32'h11111111);
    rd(A_ENRD, d); chk("R1 enable", d, 0);
    rd(A_POL, d);  chk("R1 polarity", d, 0);
    rd(A_MODE, d); chk("R1 mode", d, 0);
    rd(A_STS, d);  chk("R1 status", d, 0);
    chk("R1 irq_out", {16'h0, irq_out}, 0);

    // R2 byte lane write of one route byte
    wr(8'h04, 4'b0100, 32'h00840000);
    rd(8'h04, d); chk("R2 byte lane", d, 32'h11841111);
    wr(8'h04, 4'b0100, 32'h00110000);

    // R10 polarity/mode readback with lanes, unmapped read
    wr(A_POL, 4'b0010, 32'hFFFFFFFF);
    rd(A_POL, d); chk("R10 pol lane", d, 32'h0000FF00);
    wr(A_POL, 4'hF, 0);
    wr(A_MODE, 4'hF, 32'hA5A5A5A5);
    rd(A_MODE, d); chk("R10 mode rw", d, 32'hA5A5A5A5);
    wr(A_MODE, 4'hF, 0);
    rd(8'h3C, d); chk("R10 unmapped", d, 0);

    // R3 / R4 enable set and clear
    wr(A_ENSET, 4'hF, 32'h0000000F);
    wr(A_ENSET, 4'hF, 32'h000000F0);
    rd(A_ENRD, d); chk("R3 set keeps others", d, 32'h000000FF);
    wr(A_ENCLR, 4'hF, 32'h00000003);
    rd(A_ENRD, d); chk("R4 clear selected", d, 32'h000000FC);
    wr(A_ENCLR, 4'hF, 32'hFFFFFFFF);
    rd(A_ENRD, d); chk("R4 clear all", d, 0);

    // R9 synchroniser latency, R8 output latency (source 3, level high)
    wr(A_POL, 4'hF, 32'h8);
    wr(A_ENSET, 4'hF, 32'h8);
    @(negedge clk); bus_addr = A_STS;
    irq_in[3] = 1'b1;
    @(negedge clk); #1 chk("R9 status after 1 edge", bus_rdata, 0);
    @(negedge clk); #1 chk("R9 status after 2 edges", bus_rdata, 32'h8);
    chk("R8 out not yet", {16'h0, irq_out}, 0);
    @(negedge clk); #1 chk("R8 out after 3 edges", {16'h0, irq_out}, 32'h1);
    irq_in[3] = 1'b0;
    wait_n(4);
    rd(A_STS, d); chk("R5 level falls with input", d, 0);
    wr(A_ENCLR, 4'hF, 32'hFFFFFFFF);
    wr(A_POL, 4'hF, 0);

    // R5 / R8 / R2 vector table, level mode
    foreach (VEC[k]) begin
      logic [4:0] s;
      logic p, a;
      logic [7:0] r;
      s = VEC[k][4:0]; p = VEC[k][6]; a = VEC[k][7]; r = VEC[k][15:8];
      irq_in[s] = ~p;
      wr(A_POL, 4'hF, 32'(p) << s);
      wr({3'b000, s[4:2], 2'b00}, 4'(1) << s[1:0], 32'(r) << (8 * s[1:0]));
      wr(A_ENSET, 4'hF, 32'h1 << s);
      irq_in[s] = a ? p : ~p;
      wait_n(4);
      chk($sformatf("R8 vec%0d irq_out", k), {16'h0, irq_out}, {16'h0, exp_out(a, r)});
      rd(A_STS, d); chk($sformatf("R5 vec%0d status", k), d, 32'(a) << s);
      wr(A_ENCLR, 4'hF, 32'hFFFFFFFF);
      wait_n(2);
      chk($sformatf("R4 vec%0d out drops", k), {16'h0, irq_out}, 0);
      irq_in[s] = 1'b0;
      wr(A_POL, 4'hF, 0);
    end

    // R6 rising edge latch on source 7
    wr(A_MODE, 4'hF, 32'h80);
    wr(A_POL, 4'hF, 32'h80);
    wr(A_ENSET, 4'hF, 32'h80);
    @(negedge clk); irq_in[7] = 1'b1;
    @(negedge clk); irq_in[7] = 1'b0;
    wait_n(4);
    rd(A_STS, d); chk("R6 rising held", d, 32'h80);
    wr(A_STS, 4'hF, 32'h0);
    rd(A_STS, d); chk("R7 write 0 no effect", d, 32'h80);
    wr(A_ENCLR, 4'hF, 32'h80);
    rd(A_STS, d); chk("R7 disabled hides", d, 0);
    wr(A_ENSET, 4'hF, 32'h80);
    rd(A_STS, d); chk("R7 latch kept", d, 32'h80);
    wr(A_STS, 4'hF, 32'h80);
    rd(A_STS, d); chk("R7 write 1 clears", d, 0);

    // R6 falling edge mode
    irq_in[7] = 1'b1;
    wait_n(4);
    wr(A_POL, 4'hF, 0);
    wr(A_STS, 4'hF, 32'h80);
    wait_n(2);
    rd(A_STS, d); chk("R6 rising ignored in falling mode", d, 0);
    irq_in[7] = 1'b0;
    wait_n(4);
    rd(A_STS, d); chk("R6 falling latched", d, 32'h80);
    wr(A_STS, 4'hF, 32'h80);
    irq_in[7] = 1'b1;
    wait_n(4);
    rd(A_STS, d); chk("R6 idle high clean", d, 0);

    // R7 edge and clear in the same cycle
    @(negedge clk); irq_in[7] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_addr = A_STS; bus_be = 4'hF; bus_wdata = 32'h80; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    #1 chk("R7 edge beats clear", bus_rdata, 32'h80);
    wr(A_STS, 4'hF, 32'h80);
    rd(A_STS, d); chk("R7 later clear", d, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule